// File: doc/BRIEF.md
# UART Interrupt Status and Line Routing Unit

This block collects the interrupt events of a UART-style serial peripheral into one pending-status vector of eleven bits. Single-cycle event pulses from the receive path, the transmit path, the receive-timeout timer, the modem-status inputs and the error detectors each set one pending bit. Software sets which pending bits may drive interrupts by writing an enable register. It can read the pending vector either raw or masked by the enables, and it clears bits by writing ones to a clear register.

The block drives six interrupt outputs from the enabled pending bits. Each output has a fixed group of bits. One output is the OR of all groups. The others cover receive, transmit, receive timeout, the four modem-status bits, and the four error bits. The register port also holds a transmit-data strobe address, so every transmit data write raises the transmit pending bit. It also holds a receive level-select field that the FIFO logic around the block reads.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the enable register and every pending bit read 0, the level-select register reads 0x12, and all six interrupt outputs are low.
- R2: A 1 on `evt_set[i]` in a cycle sets pending bit i at the next clock edge. The bit map is: ring indicator 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. The raw-status read (address 3) returns the pending bits whatever the enables hold.
- R3: The masked-status read (address 4) returns the pending bits ANDed with the enable register (address 2).
- R4: A write to the clear address (address 5) clears each pending bit whose write-data bit is 1 and leaves the other pending bits unchanged. A read of the clear address returns 0.
- R5: Writes to the raw-status and masked-status addresses change no pending bit and no enable bit.
- R6: Each output is high exactly while the AND of the pending bits, the enable bits and its group is nonzero. The groups are: `irq_comb` all bits 0 to 10, `irq_rx` bit 4, `irq_tx` bit 5, `irq_rt` bit 6, `irq_ms` bits 0 to 3, `irq_err` bits 7 to 10. An output changes on the clock edge that stores the change.
- R7: Every write to the transmit-data address (address 0) sets pending bit 5. The address reads 0.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: The enable register stores write-data bits 10 to 0 and reads them back with the upper bits 0.
- R10: The level-select register (address 1) stores write-data bits 5 to 0 and reads them back with the upper bits 0.
- R11: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 11 | Event pulses, one per pending bit |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data, combinational from address |
| irq_comb | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults: a 3-bit address, 16-bit data and a 6-bit level field. With these, every decoded address and both unmapped addresses can be reached. The data bus has five bits above the eleven status bits, so the tests can show that upper write bits are dropped and read back as zero. All eleven source bits fit the data word, so each output group is driven one bit at a time. The same-cycle event and clear collision is driven directly at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int NSRC  = 11;
  localparam int NLINE = 6;

  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;
  localparam int B_PE  = 8;
  localparam int B_BE  = 9;
  localparam int B_OE  = 10;

  localparam int A_TXD = 0;
  localparam int A_LVL = 1;
  localparam int A_EN  = 2;
  localparam int A_RAW = 3;
  localparam int A_MSK = 4;
  localparam int A_CLR = 5;

  localparam int L_COMB = 0;
  localparam int L_RX   = 1;
  localparam int L_TX   = 2;
  localparam int L_RT   = 3;
  localparam int L_MS   = 4;
  localparam int L_ERR  = 5;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [2:0] {
    RS_NONE, RS_LVL, RS_EN, RS_RAW, RS_MSK
  } rd_sel_e;

  function automatic src_vec_t ms_group();
    src_vec_t m;
    m = '0;
    m[B_RI] = 1'b1; m[B_CTS] = 1'b1; m[B_DCD] = 1'b1; m[B_DSR] = 1'b1;
    return m;
  endfunction

  function automatic src_vec_t err_group();
    src_vec_t m;
    m = '0;
    m[B_FE] = 1'b1; m[B_PE] = 1'b1; m[B_BE] = 1'b1; m[B_OE] = 1'b1;
    return m;
  endfunction

  function automatic src_vec_t one_bit(input int b);
    src_vec_t m;
    m = '0;
    m[b] = 1'b1;
    return m;
  endfunction

  function automatic src_vec_t group_mask(input int line);
    case (line)
      L_COMB:  return err_group() | ms_group() | one_bit(B_RT) | one_bit(B_TX) | one_bit(B_RX);
      L_RX:    return one_bit(B_RX);
      L_TX:    return one_bit(B_TX);
      L_RT:    return one_bit(B_RT);
      L_MS:    return ms_group();
      default: return err_group();
    endcase
  endfunction

  function automatic src_vec_t next_pending(input src_vec_t cur, input src_vec_t set_v,
                                            input src_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              wr_txd,
  output logic              wr_lvl,
  output logic              wr_en,
  output logic              wr_clr,
  output rd_sel_e           rd_sel
);

  logic hit_txd, hit_lvl, hit_en, hit_raw, hit_msk, hit_clr;

  assign hit_txd = (addr == ADDR_W'(A_TXD));
  assign hit_lvl = (addr == ADDR_W'(A_LVL));
  assign hit_en  = (addr == ADDR_W'(A_EN));
  assign hit_raw = (addr == ADDR_W'(A_RAW));
  assign hit_msk = (addr == ADDR_W'(A_MSK));
  assign hit_clr = (addr == ADDR_W'(A_CLR));

  assign wr_txd = wr & hit_txd;
  assign wr_lvl = wr & hit_lvl;
  assign wr_en  = wr & hit_en;
  assign wr_clr = wr & hit_clr;

  always_comb begin
    rd_sel = RS_NONE;
    if (hit_lvl) rd_sel = RS_LVL;
    if (hit_en)  rd_sel = RS_EN;
    if (hit_raw) rd_sel = RS_RAW;
    if (hit_msk) rd_sel = RS_MSK;
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 6,
  parameter logic [LVL_W-1:0] LVL_RST = LVL_W'(6'h12)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          evt_set,
  input  logic              wr_txd,
  input  logic              wr_lvl,
  input  logic              wr_en,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output src_vec_t          pending_q,
  output src_vec_t          enable_q,
  output logic [LVL_W-1:0]  level_q
);

  src_vec_t set_vec;
  src_vec_t clr_vec;

  always_comb begin
    set_vec = evt_set;
    if (wr_txd) set_vec[B_TX] = 1'b1;
  end

  assign clr_vec = wr_clr ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      enable_q  <= '0;
      level_q   <= LVL_RST;
    end else begin
      pending_q <= next_pending(pending_q, set_vec, clr_vec);
      if (wr_en)  enable_q <= wdata[NSRC-1:0];
      if (wr_lvl) level_q  <= wdata[LVL_W-1:0];
    end
  end

endmodule

// File: rtl/irq_line_fanout.sv
module irq_line_fanout
  import irq_pkg::*;
(
  input  src_vec_t          pending,
  input  src_vec_t          enable,
  output src_vec_t          active,
  output logic [NLINE-1:0]  lines
);

  assign active = pending & enable;

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    localparam src_vec_t GMASK = group_mask(k);
    assign lines[k] = |(active & GMASK);
  end

endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_set,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_comb,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rt,
  output logic              irq_ms,
  output logic              irq_err
);

  logic             wr_txd, wr_lvl, wr_en, wr_clr;
  rd_sel_e          rd_sel;
  src_vec_t         pending_q;
  src_vec_t         enable_q;
  src_vec_t         active;
  logic [LVL_W-1:0] level_q;
  logic [NLINE-1:0] lines;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wr_txd (wr_txd),
    .wr_lvl (wr_lvl),
    .wr_en  (wr_en),
    .wr_clr (wr_clr),
    .rd_sel (rd_sel)
  );

  irq_status_reg #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_set   (evt_set),
    .wr_txd    (wr_txd),
    .wr_lvl    (wr_lvl),
    .wr_en     (wr_en),
    .wr_clr    (wr_clr),
    .wdata     (reg_wdata),
    .pending_q (pending_q),
    .enable_q  (enable_q),
    .level_q   (level_q)
  );

  irq_line_fanout u_fan (
    .pending (pending_q),
    .enable  (enable_q),
    .active  (active),
    .lines   (lines)
  );

  always_comb begin
    reg_rdata = '0;
    case (rd_sel)
      RS_LVL:  reg_rdata[LVL_W-1:0] = level_q;
      RS_EN:   reg_rdata[NSRC-1:0]  = enable_q;
      RS_RAW:  reg_rdata[NSRC-1:0]  = pending_q;
      RS_MSK:  reg_rdata[NSRC-1:0]  = active;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_comb = lines[L_COMB];
  assign irq_rx   = lines[L_RX];
  assign irq_tx   = lines[L_TX];
  assign irq_rt   = lines[L_RT];
  assign irq_ms   = lines[L_MS];
  assign irq_err  = lines[L_ERR];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_set,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_comb,
  input logic              irq_rx,
  input logic              irq_err,
  input logic [NSRC-1:0]   pending_q,
  input logic [NSRC-1:0]   enable_q
);

  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((pending_q & $past(evt_set)) == $past(evt_set)));

  p_clear_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(A_CLR)) |-> (reg_rdata == '0));

  p_clear_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_CLR))
      |=> ((pending_q & $past(reg_wdata[NSRC-1:0]) & ~$past(evt_set)) == '0));

  p_raw_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_RAW) && evt_set == '0)
      |=> ($stable(pending_q) && $stable(enable_q)));

  p_comb_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb == (|(pending_q & enable_q)));

  p_rx_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == (pending_q[B_RX] & enable_q[B_RX]));

  p_err_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == (|(pending_q[B_OE:B_FE] & enable_q[B_OE:B_FE])));

  p_txd_sets_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_TXD)) |=> pending_q[B_TX]);

endmodule

bind uart_irq_router irq_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_set   (evt_set),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_comb  (irq_comb),
  .irq_rx    (irq_rx),
  .irq_err   (irq_err),
  .pending_q (pending_q),
  .enable_q  (enable_q)
);

// File: tb/uart_irq_router_tb_top.sv
`timescale 1ns/1ps
module uart_irq_router_tb_top;

  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [10:0]   evt_set = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_comb(irq_comb), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] act);
    logic [5:0] l;
    l[0] = act != 0;
    l[1] = act[4];
    l[2] = act[5];
    l[3] = act[6];
    l[4] = (act & 11'h00F) != 0;
    l[5] = (act & 11'h780) != 0;
    return l;
  endfunction

  function automatic logic [5:0] got_lines();
    return {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb};
  endfunction

  task automatic clear_all();
    wr(5, 16'h07FF);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(3, d); chk("R1", "raw after reset", 32'(d), 0);
    rd(2, d); chk("R1", "enable after reset", 32'(d), 0);
    rd(1, d); chk("R1", "level after reset", 32'(d), 32'h12);
    chk("R1", "lines after reset", 32'(got_lines()), 0);
  endtask

  task automatic t_set_raw();
    logic [DW-1:0] d;
    pulse(11'h201);
    rd(3, d); chk("R2", "raw with mask 0", 32'(d), 32'h201);
    chk("R2", "lines masked off", 32'(got_lines()), 0);
    pulse(11'h010);
    rd(3, d); chk("R2", "raw accumulates", 32'(d), 32'h211);
    clear_all();
  endtask

  task automatic t_masked();
    logic [DW-1:0] d;
    pulse(11'h5A5);
    wr(2, 16'h0F0F);
    rd(4, d); chk("R3", "masked read", 32'(d), 32'h5A5 & 32'h70F);
    rd(3, d); chk("R3", "raw unaffected by mask", 32'(d), 32'h5A5);
    wr(2, 16'h0000);
    clear_all();
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    pulse(11'h7FF);
    wr(5, 16'h0333);
    rd(3, d); chk("R4", "partial clear", 32'(d), 32'h7FF & ~32'h333);
    rd(5, d); chk("R4", "clear reads zero", 32'(d), 0);
    clear_all();
    rd(3, d); chk("R4", "full clear", 32'(d), 0);
  endtask

  task automatic t_ro_writes();
    logic [DW-1:0] d;
    pulse(11'h0C3);
    wr(2, 16'h0055);
    wr(3, 16'hFFFF);
    wr(4, 16'hFFFF);
    wr(3, 16'h0000);
    rd(3, d); chk("R5", "raw after status writes", 32'(d), 32'h0C3);
    rd(2, d); chk("R5", "enable after status writes", 32'(d), 32'h055);
    wr(2, 16'h0000);
    clear_all();
  endtask

  task automatic t_lines();
    logic [DW-1:0] d;
    wr(2, 16'h07FF);
    for (int b = 0; b < 11; b++) begin
      pulse(11'(1 << b));
      chk("R6", $sformatf("lines for bit %0d", b), 32'(got_lines()),
          32'(exp_lines(11'(1 << b))));
      clear_all();
      chk("R6", $sformatf("lines drop bit %0d", b), 32'(got_lines()), 0);
    end
    pulse(11'h0C1);
    wr(2, 16'h0040);
    chk("R6", "only timeout enabled", 32'(got_lines()), 32'(exp_lines(11'h040)));
    wr(2, 16'h0000);
    chk("R6", "mask removes lines", 32'(got_lines()), 0);
    rd(3, d);
    clear_all();
  endtask

  task automatic t_txd();
    logic [DW-1:0] d;
    wr(0, 16'h0041);
    rd(3, d); chk("R7", "tx pending after data write", 32'(d), 32'h020);
    rd(0, d); chk("R7", "tx data reads zero", 32'(d), 0);
    wr(5, 16'h0020);
    wr(0, 16'h0000);
    rd(3, d); chk("R7", "tx set again", 32'(d), 32'h020);
    clear_all();
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    pulse(11'h001);
    @(negedge clk);
    evt_set = 11'h080; reg_addr = AW'(5); reg_wdata = 16'h0081; reg_wr = 1'b1;
    @(negedge clk);
    evt_set = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(3, d); chk("R8", "set beats clear", 32'(d), 32'h080);
    clear_all();
  endtask

  task automatic t_enable_rb();
    logic [DW-1:0] d;
    wr(2, 16'hFABC);
    rd(2, d); chk("R9", "enable readback", 32'(d), 32'h2BC);
    wr(2, 16'h0000);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    wr(1, 16'hFFE5);
    rd(1, d); chk("R10", "level readback", 32'(d), 32'h25);
    wr(1, 16'h0012);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d;
    pulse(11'h011);
    wr(6, 16'hFFFF);
    wr(7, 16'hFFFF);
    rd(6, d); chk("R11", "addr 6 reads zero", 32'(d), 0);
    rd(7, d); chk("R11", "addr 7 reads zero", 32'(d), 0);
    rd(3, d); chk("R11", "raw untouched", 32'(d), 32'h011);
    rd(2, d); chk("R11", "enable untouched", 32'(d), 0);
    rd(1, d); chk("R11", "level untouched", 32'(d), 32'h12);
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_raw();
    t_masked();
    t_clear();
    t_ro_writes();
    t_lines();
    t_txd();
    t_collide();
    t_enable_rb();
    t_level();
    t_unmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule